// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Sequencer

This block turns a stream of read requests from the core into the control and address pin activity of an external asynchronous memory whose data bus is 8 or 16 bits wide. The core presents an address with a valid/ready handshake. Each read returns as a one-cycle valid pulse on the response data port.

A read that opens a page first goes through a programmable setup phase and then a programmable strobe phase. When page mode is on, each later request is compared with the address of the beat in progress. The low address field is compared over a width set by the page length (4, 8, 16 or 32 members) and by the device width. An optional rule accepts only the next sequential member. A request that falls inside the page only changes the address pins and runs a shorter page-access phase. Chip select and read enable stay low across these beats.

Any other request, or the lack of a request when a beat ends, closes the sequence. The closing hold phase is then applied, with one optional turnaround cycle after it, and the next read starts again from the setup phase.

Top module: `page_rd_seq`

## Requirements
- R1: While reset is asserted and right after it, memCsN and memReN are 1, rspValid is 0 and reqReady is 1.
- R2: An opening read keeps memCsN low with memReN high for cfgSetup cycles, then keeps memReN low for cfgStrobe cycles. rspValid pulses in the cycle after the last strobe cycle. rspData then carries memData as sampled in that last strobe cycle.
- R3: With cfgSetup = 0, the strobe phase begins in the first cycle after the request is accepted, so no cycle has memCsN low with memReN high.
- R4: With cfgPageEn = 1, a request present in the last cycle of a beat that falls in the page is accepted in that cycle. It then runs cfgPageAcc cycles of page access, with no hold phase and memCsN and memReN kept low between the beats.
- R5: For an 8-bit device (cfgWide = 0) with cfgIncOnly = 0, a request falls in the page when address bits above bit L-1 match the previous address, where L = 2 + cfgPageLen. cfgPageLen encodes 0 = 4, 1 = 8, 2 = 16 and 3 = 32 members. Equal addresses count as in-page.
- R6: For a 16-bit device (cfgWide = 1) the compared low field is one bit wider: L = 3 + cfgPageLen.
- R7: With cfgIncOnly = 1, the high bits must match and the low L bits must equal the previous low field plus 1 (8-bit) or plus 2 (16-bit), modulo 2^L.
- R8: With cfgPageEn = 0, every read is a full sequence of setup, strobe and hold, and memCsN returns high between reads.
- R9: A sequence ends with cfgHold cycles in which memCsN and memReN stay low, after which both go high. With cfgHold = 0 both go high in the cycle after the last beat.
- R10: When turnReq is 1 at the end of a sequence, exactly one cycle follows with memCsN high and reqReady low before a new request can be accepted.
- R11: A request outside the page ends the sequence after the current beat, and that request starts again with cfgSetup setup cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgPageEn | input | 1 | Enables chaining of in-page reads |
| cfgWide | input | 1 | Device width: 0 = 8-bit, 1 = 16-bit |
| cfgPageLen | input | 2 | Page members: 0 = 4, 1 = 8, 2 = 16, 3 = 32 |
| cfgIncOnly | input | 1 | Only the next sequential member counts as in-page |
| cfgSetup | input | CW | Setup cycles (0 or more) |
| cfgStrobe | input | CW | Strobe cycles (at least 1) |
| cfgPageAcc | input | CW | Page-access cycles (at least 1) |
| cfgHold | input | CW | Hold cycles at the end of a sequence (0 or more) |
| turnReq | input | 1 | Inserts one turnaround cycle at the end of a sequence |
| reqValid | input | 1 | Read request valid |
| reqAddr | input | AW | Read request address |
| reqReady | output | 1 | Request accepted in this cycle when valid |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspData | output | DW | Read data |
| memCsN | output | 1 | Chip select, active low |
| memReN | output | 1 | Read enable, active low |
| memAddr | output | AW | Address to the device |
| memData | input | DW | Data from the device |

## Verification
In the last cycle of a beat, the capture of the current data and the acceptance of the next in-page request happen on the same edge. The address that is being sampled changes at that edge. The bench keeps the next request waiting before each beat ends and checks two things: each response carries the data of its own address, and the count of read-enable-low cycles matches a chained run with no hold between beats. Sequence closure and a waiting out-of-page request also meet at a beat end. A table of address pairs judges the in-page decision by counting chip-select release edges, and directed runs count the setup, hold and turnaround cycles.

// File: rtl/page_rd_pkg.sv
`timescale 1ns/1ps
package page_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_PAGE,
    ST_HOLD,
    ST_TURN
  } seqState_t;

  typedef struct packed {
    logic loadAddr;  // latch a new device address
    logic capture;   // sample device data, raise response
    logic pageLoad;  // the load is a chained in-page beat
  } seqCtl_t;

endpackage

// File: rtl/page_rd_ctrl.sv
`timescale 1ns/1ps
module page_rd_ctrl
  import page_rd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgPageEn,
  input  logic [CW-1:0] cfgSetup,
  input  logic [CW-1:0] cfgStrobe,
  input  logic [CW-1:0] cfgPageAcc,
  input  logic [CW-1:0] cfgHold,
  input  logic          turnReq,
  input  logic          reqValid,
  input  logic          hit,
  output logic          reqReady,
  output logic          csN,
  output logic          reN,
  output seqCtl_t       ctl
);

  seqState_t state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic lastCyc, beatEnd, chain;
  logic [CW-1:0] strobeM1, pageM1, setupM1, holdM1;

  // strobe and page-access phases last at least one cycle
  assign strobeM1 = (cfgStrobe == '0) ? '0 : cfgStrobe - 1'b1;
  assign pageM1   = (cfgPageAcc == '0) ? '0 : cfgPageAcc - 1'b1;
  assign setupM1  = cfgSetup - 1'b1;
  assign holdM1   = cfgHold - 1'b1;

  assign lastCyc  = (cnt == '0);
  assign beatEnd  = ((state == ST_STROBE) || (state == ST_PAGE)) && lastCyc;
  assign chain    = beatEnd && cfgPageEn && reqValid && hit;
  assign reqReady = (state == ST_IDLE) || chain;

  assign ctl.loadAddr = reqValid && reqReady;
  assign ctl.capture  = beatEnd;
  assign ctl.pageLoad = chain;

  assign csN = !((state == ST_SETUP) || (state == ST_STROBE) ||
                 (state == ST_PAGE) || (state == ST_HOLD));
  assign reN = !((state == ST_STROBE) || (state == ST_PAGE) ||
                 (state == ST_HOLD));

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (cfgSetup == '0) begin
            stateNxt = ST_STROBE;
            cntNxt   = strobeM1;
          end else begin
            stateNxt = ST_SETUP;
            cntNxt   = setupM1;
          end
        end
      end
      ST_SETUP: begin
        if (lastCyc) begin
          stateNxt = ST_STROBE;
          cntNxt   = strobeM1;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_STROBE, ST_PAGE: begin
        if (!lastCyc) begin
          cntNxt = cnt - 1'b1;
        end else if (chain) begin
          stateNxt = ST_PAGE;
          cntNxt   = pageM1;
        end else if (cfgHold != '0) begin
          stateNxt = ST_HOLD;
          cntNxt   = holdM1;
        end else begin
          stateNxt = turnReq ? ST_TURN : ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (lastCyc) stateNxt = turnReq ? ST_TURN : ST_IDLE;
        else         cntNxt   = cnt - 1'b1;
      end
      ST_TURN: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  // R10: a turnaround lasts exactly one cycle
  a_r10_turn_single: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TURN) |=> (state == ST_IDLE));

  // R4: page access is entered only from a finishing beat
  a_r4_page_from_beat: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAGE) |-> ($past(state) == ST_STROBE || $past(state) == ST_PAGE));

  // R9: once holding, the sequence cannot chain again
  a_r9_hold_closes: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> (state != ST_PAGE));

endmodule

// File: rtl/page_rd_dpath.sv
`timescale 1ns/1ps
module page_rd_dpath
  import page_rd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWide,
  input  logic [1:0]    cfgPageLen,
  input  logic          cfgIncOnly,
  input  logic [AW-1:0] reqAddr,
  input  seqCtl_t       ctl,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic          hit,
  output logic          rspValid,
  output logic [DW-1:0] rspData
);

  logic [2:0]    lowBits;
  logic [AW-1:0] lowMask, step, nextLow;
  logic          highSame, incOk;

  assign lowBits = 3'd2 + {1'b0, cfgPageLen} + {2'b0, cfgWide};

  for (genvar gi = 0; gi < AW; gi++) begin : g_mask
    assign lowMask[gi] = (32'(gi) < {29'd0, lowBits});
  end

  assign step     = {{(AW-2){1'b0}}, cfgWide, ~cfgWide};
  assign nextLow  = memAddr + step;
  assign highSame = ((reqAddr ^ memAddr) & ~lowMask) == '0;
  assign incOk    = ((reqAddr ^ nextLow) & lowMask) == '0;
  assign hit      = highSame && (!cfgIncOnly || incOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (ctl.loadAddr) memAddr <= reqAddr;
      rspValid <= ctl.capture;
      if (ctl.capture) rspData <= memData;
    end
  end

  // R5: a chained beat is only taken for an in-page address
  a_r5_chain_in_page: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pageLoad |-> hit);

endmodule

// File: rtl/page_rd_seq.sv
`timescale 1ns/1ps
module page_rd_seq
  import page_rd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgPageEn,
  input  logic          cfgWide,
  input  logic [1:0]    cfgPageLen,
  input  logic          cfgIncOnly,
  input  logic [CW-1:0] cfgSetup,
  input  logic [CW-1:0] cfgStrobe,
  input  logic [CW-1:0] cfgPageAcc,
  input  logic [CW-1:0] cfgHold,
  input  logic          turnReq,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  output logic          reqReady,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic          memCsN,
  output logic          memReN,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memData
);

  seqCtl_t ctl;
  logic    hit;

  page_rd_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgPageEn(cfgPageEn),
    .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgPageAcc(cfgPageAcc), .cfgHold(cfgHold),
    .turnReq(turnReq), .reqValid(reqValid), .hit(hit),
    .reqReady(reqReady), .csN(memCsN), .reN(memReN), .ctl(ctl)
  );

  page_rd_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .cfgPageLen(cfgPageLen),
    .cfgIncOnly(cfgIncOnly), .reqAddr(reqAddr), .ctl(ctl),
    .memData(memData), .memAddr(memAddr), .hit(hit),
    .rspValid(rspValid), .rspData(rspData)
  );

  // R2: a response always follows a cycle with read enable low
  a_r2_rsp_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(memReN) == 1'b0));

endmodule

// File: tb/sim_page_rd_seq.sv
`timescale 1ns/1ps
module sim_page_rd_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPageEn, cfgWide, cfgIncOnly, turnReq, reqValid;
  logic [1:0] cfgPageLen;
  logic [CW-1:0] cfgSetup, cfgStrobe, cfgPageAcc, cfgHold;
  logic [AW-1:0] reqAddr, memAddr;
  logic reqReady, rspValid, memCsN, memReN;
  logic [DW-1:0] rspData, memData;

  always #2.5 clk = ~clk;

  page_rd_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rstN(rstN), .cfgPageEn(cfgPageEn), .cfgWide(cfgWide),
    .cfgPageLen(cfgPageLen), .cfgIncOnly(cfgIncOnly), .cfgSetup(cfgSetup),
    .cfgStrobe(cfgStrobe), .cfgPageAcc(cfgPageAcc), .cfgHold(cfgHold),
    .turnReq(turnReq), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .memCsN(memCsN), .memReN(memReN), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [DW-1:0] expData(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction
  assign memData = expData(memAddr);

  // {wide, len[1:0], incOnly, prevAddr, nextAddr, inPage}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 16'h0100, 16'h0103, 1'b1},
    {1'b0, 2'd0, 1'b0, 16'h0100, 16'h0104, 1'b0},
    {1'b0, 2'd3, 1'b0, 16'h0100, 16'h011F, 1'b1},
    {1'b0, 2'd3, 1'b0, 16'h0100, 16'h0120, 1'b0},
    {1'b0, 2'd2, 1'b0, 16'h0100, 16'h0100, 1'b1},
    {1'b1, 2'd0, 1'b0, 16'h0100, 16'h0107, 1'b1},
    {1'b1, 2'd0, 1'b0, 16'h0100, 16'h0108, 1'b0},
    {1'b1, 2'd3, 1'b0, 16'h0100, 16'h013F, 1'b1},
    {1'b0, 2'd1, 1'b1, 16'h0105, 16'h0106, 1'b1},
    {1'b0, 2'd1, 1'b1, 16'h0105, 16'h0107, 1'b0},
    {1'b0, 2'd0, 1'b1, 16'h0103, 16'h0100, 1'b1},
    {1'b1, 2'd2, 1'b1, 16'h0110, 16'h0112, 1'b1},
    {1'b1, 2'd2, 1'b1, 16'h0110, 16'h0111, 1'b0},
    {1'b1, 2'd1, 1'b1, 16'h010E, 16'h0100, 1'b1}
  };

  int nChk = 0, nFail = 0;
  int setupCyc, reLowCyc, csRise, turnCyc, rdCnt;
  logic [DW-1:0] rdBuf [8];
  logic prevCs = 1'b1;
  logic [AW-1:0] addrList [8];
  int nAddr;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memCsN && memReN) setupCyc++;
      if (!memReN) reLowCyc++;
      if (memCsN && !prevCs) csRise++;
      if (memCsN && !reqReady) turnCyc++;
      if (rspValid && rdCnt < 8) begin rdBuf[rdCnt] = rspData; rdCnt++; end
      prevCs = memCsN;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    setupCyc = 0; reLowCyc = 0; csRise = 0; turnCyc = 0; rdCnt = 0;
  endtask

  task automatic setCfg(input logic pe, input logic w, input logic [1:0] len,
                        input logic inc, input int s, input int t, input int p,
                        input int h, input logic tr);
    cfgPageEn = pe; cfgWide = w; cfgPageLen = len; cfgIncOnly = inc;
    cfgSetup = CW'(s); cfgStrobe = CW'(t); cfgPageAcc = CW'(p); cfgHold = CW'(h);
    turnReq = tr;
  endtask

  task automatic feed();
    clearStats();
    for (int i = 0; i < nAddr; i++) begin
      reqValid = 1'b1;
      reqAddr  = addrList[i];
      #1;
      while (!reqReady) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    reqValid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic chkData(input string tag);
    chk({tag, " response count"}, rdCnt, nAddr);
    for (int i = 0; i < nAddr; i++)
      chk({tag, " data"}, int'(rdBuf[i]), int'(expData(addrList[i])));
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    reqValid = 1'b0; reqAddr = '0;
    setCfg(1, 0, 0, 0, 2, 3, 1, 1, 0);
    clearStats();
    repeat (3) @(negedge clk);
    chk("R1 csN in reset", int'(memCsN), 1);
    chk("R1 reN in reset", int'(memReN), 1);
    chk("R1 rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(reqReady), 1);
    chk("R1 csN after reset", int'(memCsN), 1);

    // R2 and R9: single read timing
    nAddr = 1; addrList[0] = 16'h0040;
    feed();
    chk("R2 setup cycles", setupCyc, 2);
    chk("R2 R9 read-enable low cycles", reLowCyc, 4);
    chk("R2 sequences", csRise, 1);
    chkData("R2");

    // R3: no setup
    setCfg(1, 0, 0, 0, 0, 3, 1, 1, 0);
    addrList[0] = 16'h0055;
    feed();
    chk("R3 setup cycles", setupCyc, 0);
    chk("R3 read-enable low cycles", reLowCyc, 4);
    chkData("R3");

    // R9: zero hold
    setCfg(1, 0, 0, 0, 2, 3, 1, 0, 0);
    addrList[0] = 16'h0066;
    feed();
    chk("R9 zero hold low cycles", reLowCyc, 3);
    chk("R9 zero hold sequences", csRise, 1);

    // R4: chained page beats
    setCfg(1, 0, 0, 1, 2, 3, 2, 1, 0);
    nAddr = 4;
    for (int i = 0; i < 4; i++) addrList[i] = 16'h0200 + 16'(i);
    feed();
    chk("R4 sequences", csRise, 1);
    chk("R4 setup cycles", setupCyc, 2);
    chk("R4 read-enable low cycles", reLowCyc, 10);
    chkData("R4");

    // R8: page mode off
    setCfg(0, 0, 0, 1, 2, 3, 2, 1, 0);
    feed();
    chk("R8 sequences", csRise, 4);
    chk("R8 setup cycles", setupCyc, 8);
    chk("R8 read-enable low cycles", reLowCyc, 16);
    chkData("R8");

    // R11: out-of-page request restarts with setup
    setCfg(1, 0, 0, 0, 2, 3, 1, 1, 0);
    addrList[0] = 16'h0200; addrList[1] = 16'h0201;
    addrList[2] = 16'h0300; addrList[3] = 16'h0301;
    feed();
    chk("R11 sequences", csRise, 2);
    chk("R11 setup cycles", setupCyc, 4);
    chk("R11 read-enable low cycles", reLowCyc, 10);
    chkData("R11");

    // R10: turnaround
    setCfg(1, 0, 0, 0, 2, 3, 1, 1, 1);
    feed();
    chk("R10 turnaround cycles burst", turnCyc, 2);
    nAddr = 1; addrList[0] = 16'h0077;
    feed();
    chk("R10 turnaround cycles single", turnCyc, 1);
    setCfg(1, 0, 0, 0, 2, 3, 1, 0, 1);
    feed();
    chk("R10 turnaround after zero hold", turnCyc, 1);

    // R5 R6 R7: in-page decision table
    nAddr = 2;
    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      string tag;
      e = VEC[v];
      tag = e[33] ? "R7" : (e[36] ? "R6" : "R5");
      setCfg(1, e[36], e[35:34], e[33], 2, 3, 1, 1, 0);
      addrList[0] = e[32:17];
      addrList[1] = e[16:1];
      feed();
      chk($sformatf("%s row %0d sequences", tag, v), csRise, e[0] ? 1 : 2);
      chkData(tag);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule